// File: doc/BRIEF.md
# Synchronous-Read Register File with Write Bypass

This block is the architectural operand store of an in-order pipeline. It holds two banks of registers, one general-purpose and one floating-point, in a single array. The array is read on a clock edge, the way block RAM is read. It has three read ports (A, B and C) and one write port. The decode stage presents three operand addresses every cycle, one stage before the operands are needed. The data for those addresses leaves the block on the following cycle. Each operand address carries its own bank selector, so the three ports can mix banks freely.

A write is committed to the array at the same edge that samples the read addresses. The array read at that edge still returns the old contents. For that reason the block keeps a copy of the last write, and each read port swaps in the written value when its captured address matches. While the pipeline is stalled, the captured addresses are read again in place of the incoming ones. A debug agent can read any register. Its request waits until a cycle in which port B is free, then borrows that port's array read. The debug result comes back with a one-cycle strobe. Port B's own output is held steady in that cycle.

Top module: `regfile_sync_bypass`

## Requirements
- R1: The read data on each of ports A, B and C, in the cycle after an edge, is the contents of the register whose address was captured at that edge. Those contents include every write committed at or before that edge.
- R2: A register address is {fp, idx}. fp=1 selects the floating-point bank and fp=0 the general-purpose bank. The two banks hold separate values for the same idx, and each read port's selector is independent of the other ports.
- R3: While `stall` is high, the read addresses captured earlier are read again and the incoming read addresses are ignored. With no write to those registers, the read outputs stay unchanged.
- R4: When a read address is captured at the same edge at which a write to that register is committed, the read output shows the newly written data.
- R5: When `wr_en` is low, the values on the write address and write data inputs have no effect on the array or on any read output.
- R6: A pending debug read is serviced only in a cycle where `stall` is low and port B is unused, meaning `in_valid` is low or `b_used` is low. Otherwise it stays pending.
- R7: `dbg_valid` is high for exactly one cycle, the cycle after the debug read is serviced. In that cycle `dbg_data` holds the requested register's contents, including a write committed at the servicing edge.
- R8: In the cycle where `dbg_valid` is high, `rd_data_b` keeps the value it had in the previous cycle.
- R9: A `dbg_req` that arrives while a debug read is already pending is ignored. The pending address is kept.
- R10: During reset and up to the first edge after reset is released, all read outputs and `dbg_data` are zero and `dbg_valid` is low. Reset clears any pending debug request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| stall | input | 1 | Pipeline stall: read the captured addresses again |
| in_valid | input | 1 | The incoming instruction is valid |
| b_used | input | 1 | The incoming instruction uses operand B |
| rd_fp_a | input | 1 | Bank selector, port A |
| rd_idx_a | input | 5 | Register index, port A |
| rd_fp_b | input | 1 | Bank selector, port B |
| rd_idx_b | input | 5 | Register index, port B |
| rd_fp_c | input | 1 | Bank selector, port C |
| rd_idx_c | input | 5 | Register index, port C |
| wr_en | input | 1 | Write enable |
| wr_fp | input | 1 | Bank selector of the write |
| wr_idx | input | 5 | Register index of the write |
| wr_data | input | 64 | Write data |
| dbg_req | input | 1 | Debug read request (pulse) |
| dbg_fp | input | 1 | Bank selector of the debug read |
| dbg_idx | input | 5 | Register index of the debug read |
| rd_data_a | output | 64 | Read data, port A |
| rd_data_b | output | 64 | Read data, port B |
| rd_data_c | output | 64 | Read data, port C |
| dbg_valid | output | 1 | Debug result strobe |
| dbg_data | output | 64 | Debug result data |

## Verification
Some properties are checked on every cycle. These are: the captured addresses stay frozen through a stall, the debug strobe appears only after a cycle in which port B was free, the strobe never lasts two cycles in a row, a pending request keeps its address until it is serviced, and `rd_data_b` holds while the strobe is high. Data correctness cannot be expressed that way. This covers the swap-in of a write committed at the same edge, the separation of the two banks, writes with the enable low, and the contents of a debug result. Only the bench's reference model shows these, comparing against the outputs on every clock. Directed scenarios cover the same-edge writes, bank mixing, stalls with writes, blocked and overlapping debug requests, and a long random run.

// File: rtl/rf_pkg.sv
package rf_pkg;
   localparam int unsigned RF_RD_PORTS = 3;
   localparam int unsigned RF_PORT_A   = 0;
   localparam int unsigned RF_PORT_B   = 1;
   localparam int unsigned RF_PORT_C   = 2;
endpackage

// File: rtl/rf_storage.sv
module rf_storage #(
   parameter int unsigned DATA_W  = 64,
   parameter int unsigned ENTRIES = 64,
   parameter int unsigned NRD     = 3,
   localparam int unsigned AW     = $clog2(ENTRIES)
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          we,
   input  logic [AW-1:0]                 waddr,
   input  logic [DATA_W-1:0]             wdata,
   input  logic [NRD-1:0][AW-1:0]        raddr,
   output logic [NRD-1:0][DATA_W-1:0]    rdata
);
   if (ENTRIES < 2 || (2 ** AW) != ENTRIES) begin : g_bad_entries
      $error("rf_storage: ENTRIES must be a power of two");
   end

   logic [DATA_W-1:0] mem [ENTRIES];

   always_ff @(posedge clk) begin
      if (we) mem[waddr] <= wdata;
   end

   // One synchronous, read-first port per reader
   for (genvar p = 0; p < NRD; p++) begin : g_rd
      logic [DATA_W-1:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) q <= '0;
         else        q <= mem[raddr[p]];
      end
      assign rdata[p] = q;
   end
endmodule

// File: rtl/rf_bypass.sv
module rf_bypass #(
   parameter int unsigned DATA_W = 64,
   parameter int unsigned AW     = 6
) (
   input  logic [DATA_W-1:0] ram_q,
   input  logic [AW-1:0]     rd_addr,
   input  logic              lw_en,
   input  logic [AW-1:0]     lw_addr,
   input  logic [DATA_W-1:0] lw_data,
   output logic [DATA_W-1:0] dout
);
   always_comb begin
      if (lw_en && (lw_addr == rd_addr)) dout = lw_data;
      else                               dout = ram_q;
   end
endmodule

// File: rtl/rf_dbg_ctl.sv
module rf_dbg_ctl #(
   parameter int unsigned AW = 6
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          req,
   input  logic [AW-1:0] req_addr,
   input  logic          port_free,
   output logic          fire,
   output logic          pend,
   output logic [AW-1:0] addr_q,
   output logic          vld
);
   assign fire = pend && port_free;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend   <= 1'b0;
         addr_q <= '0;
         vld    <= 1'b0;
      end else begin
         vld <= fire;
         if (fire) begin
            pend <= 1'b0;
         end else if (req && !pend) begin
            pend   <= 1'b1;
            addr_q <= req_addr;
         end
      end
   end

   assert_dbg_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
      vld |=> !vld);
   assert_dbg_keep_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (pend && !port_free) |=> (pend && $stable(addr_q)));
endmodule

// File: rtl/regfile_sync_bypass.sv
module regfile_sync_bypass
   import rf_pkg::*;
#(
   parameter int unsigned DATA_W    = 64,
   parameter int unsigned BANK_REGS = 32,
   localparam int unsigned IDX_W    = $clog2(BANK_REGS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              stall,
   input  logic              in_valid,
   input  logic              b_used,
   input  logic              rd_fp_a,
   input  logic [IDX_W-1:0]  rd_idx_a,
   input  logic              rd_fp_b,
   input  logic [IDX_W-1:0]  rd_idx_b,
   input  logic              rd_fp_c,
   input  logic [IDX_W-1:0]  rd_idx_c,
   input  logic              wr_en,
   input  logic              wr_fp,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              dbg_req,
   input  logic              dbg_fp,
   input  logic [IDX_W-1:0]  dbg_idx,
   output logic [DATA_W-1:0] rd_data_a,
   output logic [DATA_W-1:0] rd_data_b,
   output logic [DATA_W-1:0] rd_data_c,
   output logic              dbg_valid,
   output logic [DATA_W-1:0] dbg_data
);
   localparam int unsigned AW      = IDX_W + 1;
   localparam int unsigned ENTRIES = 2 * BANK_REGS;
   localparam int unsigned NRD     = RF_RD_PORTS;

   if (BANK_REGS < 2 || (2 ** IDX_W) != BANK_REGS) begin : g_bad_bank
      $error("regfile_sync_bypass: BANK_REGS must be a power of two");
   end
   if (DATA_W == 0) begin : g_bad_width
      $error("regfile_sync_bypass: DATA_W must be non-zero");
   end

   logic [NRD-1:0][AW-1:0]     addr_in, addr_q, ram_addr;
   logic [NRD-1:0][DATA_W-1:0] ram_q;
   logic                       lw_en;
   logic [AW-1:0]              lw_addr;
   logic [DATA_W-1:0]          lw_data;
   logic                       b_free, dbg_fire, dbg_pend;
   logic [AW-1:0]              dbg_addr;
   logic [DATA_W-1:0]          b_hold;

   assign addr_in[RF_PORT_A] = {rd_fp_a, rd_idx_a};
   assign addr_in[RF_PORT_B] = {rd_fp_b, rd_idx_b};
   assign addr_in[RF_PORT_C] = {rd_fp_c, rd_idx_c};

   assign b_free = !stall && !(in_valid && b_used);

   // Array address per port; port B may be lent to the debug reader
   for (genvar p = 0; p < NRD; p++) begin : g_addr
      if (p == RF_PORT_B) begin : g_shared
         assign ram_addr[p] = dbg_fire ? dbg_addr : (stall ? addr_q[p] : addr_in[p]);
      end else begin : g_plain
         assign ram_addr[p] = stall ? addr_q[p] : addr_in[p];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      addr_q <= '0;
      else if (!stall) addr_q <= addr_in;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lw_en   <= 1'b0;
         lw_addr <= '0;
         lw_data <= '0;
      end else begin
         lw_en   <= wr_en;
         lw_addr <= {wr_fp, wr_idx};
         lw_data <= wr_data;
      end
   end

   rf_storage #(.DATA_W(DATA_W), .ENTRIES(ENTRIES), .NRD(NRD)) u_store (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (wr_en),
      .waddr ({wr_fp, wr_idx}),
      .wdata (wr_data),
      .raddr (ram_addr),
      .rdata (ram_q)
   );

   rf_dbg_ctl #(.AW(AW)) u_dbg (
      .clk       (clk),
      .rst_n     (rst_n),
      .req       (dbg_req),
      .req_addr  ({dbg_fp, dbg_idx}),
      .port_free (b_free),
      .fire      (dbg_fire),
      .pend      (dbg_pend),
      .addr_q    (dbg_addr),
      .vld       (dbg_valid)
   );

   // Bypass muxes: one per read port plus one for the debug result
   logic [DATA_W-1:0] byp_src [NRD+1];
   logic [AW-1:0]     byp_cmp [NRD+1];
   logic [DATA_W-1:0] byp_out [NRD+1];

   for (genvar k = 0; k <= NRD; k++) begin : g_byp
      if (k < NRD) begin : g_port
         assign byp_src[k] = ram_q[k];
         assign byp_cmp[k] = addr_q[k];
      end else begin : g_debug
         assign byp_src[k] = ram_q[RF_PORT_B];
         assign byp_cmp[k] = dbg_addr;
      end
      rf_bypass #(.DATA_W(DATA_W), .AW(AW)) u_byp (
         .ram_q   (byp_src[k]),
         .rd_addr (byp_cmp[k]),
         .lw_en   (lw_en),
         .lw_addr (lw_addr),
         .lw_data (lw_data),
         .dout    (byp_out[k])
      );
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) b_hold <= '0;
      else        b_hold <= rd_data_b;
   end

   assign rd_data_a = byp_out[RF_PORT_A];
   assign rd_data_b = dbg_valid ? b_hold : byp_out[RF_PORT_B];
   assign rd_data_c = byp_out[RF_PORT_C];
   assign dbg_data  = byp_out[NRD];

   assert_stall_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      stall |=> $stable(addr_q));
   assert_dbg_free_R6: assert property (@(posedge clk) disable iff (!rst_n)
      dbg_valid |-> $past(!stall && !(in_valid && b_used)));
   assert_b_steady_R8: assert property (@(posedge clk) disable iff (!rst_n)
      dbg_valid |-> (rd_data_b == $past(rd_data_b)));
   assert_dbg_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
      dbg_valid |-> !dbg_pend);
endmodule

// File: tb/tb_regfile_sync_bypass.sv
`timescale 1ns/1ps
module tb_regfile_sync_bypass;
   logic clk = 1'b0;
   always #2 clk = ~clk;

   logic        rst_n, stall, in_valid, b_used;
   logic        rd_fp_a, rd_fp_b, rd_fp_c, wr_en, wr_fp, dbg_req, dbg_fp;
   logic [4:0]  rd_idx_a, rd_idx_b, rd_idx_c, wr_idx, dbg_idx;
   logic [63:0] wr_data;
   logic [63:0] rd_data_a, rd_data_b, rd_data_c, dbg_data;
   logic        dbg_valid;

   regfile_sync_bypass dut (.*);

   int    n_chk = 0, n_fail = 0;
   bit    done = 0;
   string cur_tag = "R10";

   // Reference model state
   logic [63:0] m_mem [64];
   bit          m_known [64];
   logic [5:0]  m_addr [3];
   bit          m_pend;
   logic [5:0]  m_daddr;
   logic [63:0] e_rd [3];
   bit          e_k [3];
   bit          e_dv;
   logic [63:0] e_dd;
   bit          e_dk;

   initial for (int i = 0; i < 64; i++) m_known[i] = 0;

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int p = 0; p < 3; p++) begin m_addr[p] = '0; e_rd[p] = '0; e_k[p] = 1; end
         m_pend = 0; m_daddr = '0; e_dv = 0; e_dd = '0; e_dk = 1;
      end else begin
         logic [5:0] ra [3];
         bit fire;
         if (stall) ra = m_addr;
         else begin
            ra[0] = {rd_fp_a, rd_idx_a};
            ra[1] = {rd_fp_b, rd_idx_b};
            ra[2] = {rd_fp_c, rd_idx_c};
         end
         m_addr = ra;
         fire = m_pend && !stall && !(in_valid && b_used);
         if (wr_en) begin m_mem[{wr_fp, wr_idx}] = wr_data; m_known[{wr_fp, wr_idx}] = 1; end
         for (int p = 0; p < 3; p++) begin
            if (!(p == 1 && fire)) begin e_rd[p] = m_mem[ra[p]]; e_k[p] = m_known[ra[p]]; end
         end
         e_dv = fire;
         if (fire) begin e_dd = m_mem[m_daddr]; e_dk = m_known[m_daddr]; end
         if (fire) m_pend = 0;
         else if (dbg_req && !m_pend) begin m_pend = 1; m_daddr = {dbg_fp, dbg_idx}; end
      end
   end

   task automatic chk(string what, bit known, logic [63:0] act, logic [63:0] exp);
      if (!known) return;
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s act=%h exp=%h", cur_tag, what, act, exp);
      end
   endtask

   always @(negedge clk) begin
      if (!done) begin
         chk("rd_data_a", e_k[0], rd_data_a, e_rd[0]);
         chk("rd_data_b", e_k[1], rd_data_b, e_rd[1]);
         chk("rd_data_c", e_k[2], rd_data_c, e_rd[2]);
         chk("dbg_valid", 1, {63'd0, dbg_valid}, {63'd0, e_dv});
         if (e_dv) chk("dbg_data", e_dk, dbg_data, e_dd);
      end
   end

   function automatic logic [63:0] pat(int a, int salt);
      return 64'hA5C3_0000_0000_0000 ^ (64'(a) * 64'h0001_0203_0405_0607) ^ (64'(salt) << 40);
   endfunction

   task automatic set_rd(int a, int b, int c);
      {rd_fp_a, rd_idx_a} = 6'(a);
      {rd_fp_b, rd_idx_b} = 6'(b);
      {rd_fp_c, rd_idx_c} = 6'(c);
   endtask

   task automatic set_wr(bit en, int a, logic [63:0] d);
      wr_en = en; {wr_fp, wr_idx} = 6'(a); wr_data = d;
   endtask

   task automatic step(int n = 1);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      #800000;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
   end

   initial begin
      rst_n = 0; stall = 0; in_valid = 0; b_used = 0;
      set_rd(0, 0, 0); set_wr(0, 0, '0);
      dbg_req = 1; dbg_fp = 0; dbg_idx = 5'd3;
      // R10: outputs zero and no strobe through reset
      cur_tag = "R10";
      step(4);
      dbg_req = 0;
      rst_n = 1;
      step(1);

      // R2: fill both banks, same idx gets distinct data per bank
      cur_tag = "R2";
      in_valid = 1; b_used = 1;
      for (int i = 0; i < 64; i++) begin
         set_wr(1, i, pat(i, 0));
         set_rd(i, (i + 63) % 64, i ^ 32);
         step(1);
      end
      set_wr(0, 0, '0);
      for (int i = 0; i < 32; i++) begin
         set_rd(i, i + 32, (i * 7) % 64);
         step(1);
      end

      // R1: read sweep without writes
      cur_tag = "R1";
      for (int i = 0; i < 64; i++) begin
         set_rd(63 - i, (i * 5) % 64, (i * 11) % 64);
         step(1);
      end

      // R4: write and read of the same register at the same edge, on every port
      cur_tag = "R4";
      for (int i = 0; i < 12; i++) begin
         set_wr(1, i * 5 % 64, pat(i, 4));
         set_rd(i * 5 % 64, i * 5 % 64, i * 5 % 64);
         step(1);
      end
      set_wr(0, 0, '0);
      step(1);

      // R5: disabled write with matching address and junk data
      cur_tag = "R5";
      for (int i = 0; i < 8; i++) begin
         set_wr(0, i + 40, 64'hDEAD_BEEF_0BAD_F00D ^ 64'(i));
         set_rd(i + 40, i + 40, i + 40);
         step(1);
      end
      step(1);

      // R3: stall re-reads captured addresses, with and without writes
      cur_tag = "R3";
      set_rd(7, 39, 20);
      step(1);
      stall = 1;
      for (int i = 0; i < 4; i++) begin set_rd(i, i + 1, i + 2); step(1); end
      set_wr(1, 39, pat(39, 9));
      step(1);
      set_wr(0, 0, '0);
      step(2);
      stall = 0;
      step(2);

      // R6: debug held while port B busy or stalled, then serviced
      cur_tag = "R6";
      in_valid = 1; b_used = 1;
      set_rd(1, 2, 3);
      dbg_req = 1; {dbg_fp, dbg_idx} = 6'd45;
      step(1);
      dbg_req = 0;
      step(3);
      stall = 1; in_valid = 0;
      step(2);
      stall = 0;
      // R8: port B output held in strobe cycle
      cur_tag = "R8";
      step(3);

      // R9: second request while pending is ignored
      cur_tag = "R9";
      in_valid = 1; b_used = 1;
      dbg_req = 1; {dbg_fp, dbg_idx} = 6'd10;
      step(1);
      {dbg_fp, dbg_idx} = 6'd50;
      step(2);
      dbg_req = 0;
      b_used = 0;
      step(3);

      // R7: debug result includes write committed at the servicing edge
      cur_tag = "R7";
      b_used = 1;
      dbg_req = 1; {dbg_fp, dbg_idx} = 6'd22;
      step(1);
      dbg_req = 0;
      b_used = 0;
      set_wr(1, 22, pat(22, 7));
      step(1);
      set_wr(0, 0, '0);
      step(3);

      // R1: random traffic mixing every feature
      cur_tag = "R1";
      for (int i = 0; i < 4000; i++) begin
         set_rd($urandom % 64, $urandom % 64, $urandom % 64);
         set_wr(($urandom % 3) != 0, $urandom % 64, {$urandom, $urandom});
         stall    = ($urandom % 5) == 0;
         in_valid = ($urandom % 2) == 0;
         b_used   = ($urandom % 2) == 0;
         dbg_req  = ($urandom % 4) == 0;
         {dbg_fp, dbg_idx} = 6'($urandom % 64);
         step(1);
      end
      stall = 0; dbg_req = 0; set_wr(0, 0, '0);
      step(3);

      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
   end
endmodule